// File: doc/BRIEF.md
# Banked Edge Interrupt Vector Controller

This block gathers 128 edge-triggered interrupt sources into four 32-bit pending banks. Each bank has a matching enable bank. Each bank drives one request line toward a parent interrupt controller. A source sets its pending bit on a low-to-high transition. The bit then stays latched until software acknowledges it by writing a one to that bit position. A handler reads the pending banks to find what fired. It masks or unmasks individual vectors with a read-modify-write of the enable banks.

The register port is a plain 32-bit bus with a byte address, a write strobe, write data and read data. Reads are combinational from the current address. Writes take effect at the clock edge where the strobe is sampled high. The sources arrive as one 128-bit vector.

Top module: `vecbank_intc`

## Requirements
- R1: After reset every pending bit and every enable bit is zero, all request lines are low, and every bank reads as zero.
- R2: Vector n lives in bank n/32 at bit n mod 32. Its pending bit becomes set after the first clock edge at which the source is one and was zero at the previous edge (the previous sample is zero after reset). A source held high does not set the bit again after an acknowledge, and a falling source sets nothing.
- R3: A write to byte offset 4*i (i = 0..3) clears each pending bit of bank i whose data bit is one and leaves bits written as zero unchanged.
- R4: When a rising edge and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R5: Enable bank i sits at byte offset 0x20 + 4*i. It is an ordinary read/write register, and a one enables the vector.
- R6: Request line i is high exactly while some bit of bank i is both pending and enabled.
- R7: A read of pending bank i returns the latched bits whatever the enable bank holds.
- R8: Reads of any other offset return zero, including the misaligned offsets and 0x10 to 0x1F. Writes to those offsets change neither pending nor enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_in | input | 128 | Interrupt sources, vector n on bit n |
| irq_out | output | 4 | Request lines, line i serves bank i |

## Verification
A wrong pending bit shows up on the very next read of its bank. If the vector is enabled, it also shows on that bank's request line in the same cycle it is wrong, because the lines are decoded straight from the latched state. A corrupted enable bit shows up only when its vector is pending. For that reason the bench reads the enable banks back directly and also pairs enabled and masked pending vectors. Errors in the edge detector appear as a missed set or a spurious re-set after an acknowledge. The bench therefore holds sources high across acknowledges and drops them afterwards.

// File: rtl/vecbank_intc.sv
module vecbank_intc #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int ENA_OFS   = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [BANK_W-1:0]           bus_wdata,
  output logic [BANK_W-1:0]           bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0] src_in,
  output logic [NUM_BANKS-1:0]        irq_out
);
  localparam int NV     = NUM_BANKS * BANK_W;
  localparam int STRIDE = BANK_W / 8;

  logic [NV-1:0] src_q, pend_q, en_q;
  logic [NV-1:0] clr_v, en_d;
  logic [BANK_W-1:0] rd_term [2*NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic pend_hit, en_hit;
    assign pend_hit = bus_addr == ADDR_W'(b * STRIDE);
    assign en_hit   = bus_addr == ADDR_W'(ENA_OFS + b * STRIDE);
    assign clr_v[b*BANK_W +: BANK_W] = (bus_we && pend_hit) ? bus_wdata : '0;
    assign en_d[b*BANK_W +: BANK_W]  = (bus_we && en_hit) ? bus_wdata
                                                          : en_q[b*BANK_W +: BANK_W];
    assign irq_out[b] = |(pend_q[b*BANK_W +: BANK_W] & en_q[b*BANK_W +: BANK_W]);
    assign rd_term[2*b]   = pend_hit ? pend_q[b*BANK_W +: BANK_W] : '0;
    assign rd_term[2*b+1] = en_hit   ? en_q[b*BANK_W +: BANK_W]   : '0;
  end

  always_comb begin
    bus_rdata = '0;
    for (int t = 0; t < 2*NUM_BANKS; t++) bus_rdata |= rd_term[t];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      src_q  <= src_in;
      pend_q <= (pend_q & ~clr_v) | (src_in & ~src_q);
      en_q   <= en_d;
    end
  end
endmodule

module vecbank_intc_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int ENA_OFS   = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic                        bus_we,
  input logic [BANK_W-1:0]           bus_wdata,
  input logic [BANK_W-1:0]           bus_rdata,
  input logic [NUM_BANKS*BANK_W-1:0] src_in,
  input logic [NUM_BANKS-1:0]        irq_out,
  input logic [NUM_BANKS*BANK_W-1:0] src_q,
  input logic [NUM_BANKS*BANK_W-1:0] pend_q,
  input logic [NUM_BANKS*BANK_W-1:0] en_q
);
  localparam int NV     = NUM_BANKS * BANK_W;
  localparam int STRIDE = BANK_W / 8;
  localparam int SPAN   = NUM_BANKS * STRIDE;

  logic [NV-1:0] rise;
  logic          mapped;
  assign rise   = src_in & ~src_q;
  assign mapped = (int'(bus_addr) % STRIDE == 0) &&
                  ((int'(bus_addr) < SPAN) ||
                   (int'(bus_addr) >= ENA_OFS && int'(bus_addr) < ENA_OFS + SPAN));

  a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

  a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !mapped) |=> (en_q == $past(en_q)) && (($past(pend_q) & ~pend_q) == '0));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && int'(bus_addr) == b*STRIDE) |=>
      ((pend_q[b*BANK_W +: BANK_W] & $past(bus_wdata & ~rise[b*BANK_W +: BANK_W])) == '0));
    a_r5_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && int'(bus_addr) == ENA_OFS + b*STRIDE) |=>
      (en_q[b*BANK_W +: BANK_W] == $past(bus_wdata)));
    a_r6_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[b] |-> (pend_q[b*BANK_W +: BANK_W] != '0) && (en_q[b*BANK_W +: BANK_W] != '0));
    a_r6_no_lost_irq: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q[b*BANK_W +: BANK_W] & en_q[b*BANK_W +: BANK_W]) != '0) |-> irq_out[b]);
    a_r7_raw_read: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bus_addr) == b*STRIDE) |-> (bus_rdata == pend_q[b*BANK_W +: BANK_W]));
  end
endmodule

bind vecbank_intc vecbank_intc_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .ENA_OFS(ENA_OFS)
) u_chk (.*);

// File: tb/vecbank_intc_tb.sv
module vecbank_intc_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] src_in = '0;
  logic [3:0]   irq_out;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; bit is_irq; string tag; } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  vecbank_intc u_dut (.*);

  task automatic step();
    @(negedge clk); #0.5;
  endtask

  task automatic exp_read(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    step();
    bus_addr = a; bus_we = 1'b0;
    it.exp = e; it.is_irq = 1'b0; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic exp_irq(input logic [3:0] e, input string tag);
    item_t it;
    step();
    it.exp = {28'b0, e}; it.is_irq = 1'b1; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step();
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    step();
    bus_we = 1'b0;
  endtask

  task automatic src_set(input int n, input logic v);
    step();
    src_in[n] = v;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = sb.pop_front();
        got = it.is_irq ? {28'b0, irq_out} : bus_rdata;
        checks++;
        if (got !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, got, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    step(); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      exp_read(8'(4*i), 32'h0, "R1 pending reset");
      exp_read(8'(32 + 4*i), 32'h0, "R1 enable reset");
    end
    exp_irq(4'h0, "R1 irq reset");

    src_set(5, 1'b1);
    exp_read(8'h00, 32'h0000_0020, "R2 vector 5 latched");
    exp_irq(4'h0, "R6 masked vector stays quiet");
    wr(8'h20, 32'h0000_0020);
    exp_read(8'h20, 32'h0000_0020, "R5 enable readback");
    exp_irq(4'h1, "R6 line 0 raised");

    src_set(40, 1'b1);
    exp_read(8'h04, 32'h0000_0100, "R7 raw read of masked bank 1");
    exp_irq(4'h1, "R6 line 1 masked");

    wr(8'h00, 32'hFFFF_FFFF);
    exp_read(8'h00, 32'h0, "R3 bank 0 cleared, held source no reset");
    exp_irq(4'h0, "R6 line 0 dropped");
    src_set(5, 1'b0);
    exp_read(8'h00, 32'h0, "R2 falling edge sets nothing");

    wr(8'h04, 32'h0000_0000);
    exp_read(8'h04, 32'h0000_0100, "R3 zero write keeps bits");
    wr(8'h04, 32'h0000_0200);
    exp_read(8'h04, 32'h0000_0100, "R3 other bit clear keeps bit 8");

    step();
    src_in[100] = 1'b1; bus_addr = 8'h0C; bus_we = 1'b1; bus_wdata = 32'h0000_0010;
    step();
    bus_we = 1'b0;
    exp_read(8'h0C, 32'h0000_0010, "R4 set wins over clear");

    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h21, 32'hFFFF_FFFF);
    exp_read(8'h10, 32'h0, "R8 unmapped read");
    exp_read(8'h21, 32'h0, "R8 misaligned read");
    exp_read(8'h20, 32'h0000_0020, "R8 enable untouched");
    exp_read(8'h24, 32'h0, "R8 enable bank 1 untouched");
    exp_read(8'h04, 32'h0000_0100, "R8 pending untouched");
    exp_read(8'h0C, 32'h0000_0010, "R8 pending bank 3 untouched");

    src_set(127, 1'b1);
    wr(8'h2C, 32'h8000_0000);
    wr(8'h24, 32'h0000_0100);
    exp_read(8'h0C, 32'h8000_0010, "R2 vector 127 in bank 3 bit 31");
    exp_irq(4'hA, "R6 lines 1 and 3");
    wr(8'h24, 32'h0);
    exp_irq(4'h8, "R5 mask bank 1 drops line 1");
    wr(8'h0C, 32'h8000_0000);
    exp_irq(4'h0, "R3 acknowledge drops line 3");
    exp_read(8'h0C, 32'h0000_0010, "R3 bank 3 after acknowledge");

    repeat (3) step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule